// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four level-sensitive shared PCI interrupt lines onto sixteen inputs of a legacy interrupt controller. Each line has a one-byte routing register. A value below sixteen names the controller input the line drives. Any larger value disconnects the line. When several enabled lines name the same input, that input carries the OR of their levels. The sixteen outputs are registered, and on every cycle they are recomputed from the current line levels and routing bytes. A rewrite of any routing byte therefore rebuilds the whole output picture with no extra sequencing.

Software reaches the routing bytes through a small configuration port. The port takes a dword index, a 32-bit data word and four byte enables. The block also contains two combinational helpers for the surrounding fabric. The first is a slot swizzle that turns a device's slot number and interrupt pin into the shared line that pin uses. The second is a route query that reports whether a line is connected and, if so, to which controller input.

Top module: `intx_router`

## Requirements
- R1: While rstN is low at a clock edge, all sixteen outputs clear to 0 and every routing byte becomes 0x80, so every line starts disconnected and the query reports disabled.
- R2: When a line's routing byte holds a value v < 16 and the line is high, output v is high after the next clock edge. A change on lineLevel appears on irqOut one edge later.
- R3: When a line's routing byte is 16 or more, that line drives no output, and toggling its level leaves irqOut unchanged.
- R4: Each output is the OR of the levels of all enabled lines routed to it. With two lines routed to the same output, the output stays high until both lines are low.
- R5: A routing write takes effect at the clock edge where cfgWrEn is sampled high. The outputs reflect the new routing at the following edge, so an asserted line moves from its old output to its new output in that edge and the old output drops.
- R6: A write with cfgDwAddr = 0x18 (byte offsets 0x60 to 0x63) updates routing byte i from cfgWrData[8i+7:8i] for each set cfgByteEn[i], with line A at byte 0 through line D at byte 3. Writes to any other dword index, and byte lanes whose enable is clear, leave every routing byte unchanged.
- R7: cfgRdData returns the four routing bytes (line A in bits 7:0) when cfgDwAddr = 0x18, and 0 for any other index.
- R8: swizPirq = (devPin + devSlot − 1) mod 4, where devPin 0 to 3 stands for INTA to INTD.
- R9: For the line selected by qryLine, qryEnable = 1 and qryTarget = routing byte when the byte is below 16. Otherwise qryEnable = 0 and qryTarget = 5'h1F.
- R10: Each line drives at most one output, so the number of high outputs never exceeds the number of lines that were high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lineLevel | input | 4 | Levels of shared lines A to D (bit 0 = A) |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDwAddr | input | 6 | Configuration dword index (byte offset / 4) |
| cfgByteEn | input | 4 | Byte-lane enables for the write |
| cfgWrData | input | 32 | Write data, little-endian lanes |
| cfgRdData | output | 32 | Read data for cfgDwAddr |
| devSlot | input | 5 | Device slot number for the swizzle |
| devPin | input | 2 | Device interrupt pin, 0 = INTA .. 3 = INTD |
| swizPirq | output | 2 | Shared line used by that device pin |
| qryLine | input | 2 | Line selected for the route query |
| qryEnable | output | 1 | Selected line is connected |
| qryTarget | output | 5 | Controller input of the selected line, 5'h1F if disconnected |
| irqOut | output | 16 | Registered controller input levels |

## Verification
The assertions check the properties that hold on every cycle. Outputs stay low whenever no line was high. Outputs never outnumber the high lines. Routing bytes stay unchanged without a write strobe. The query's target is always consistent with its enable flag. The reset values are checked as well. The bench scenarios are needed for the behaviour that depends on history. These are the OR merge of two lines that hold an output high until both release, an asserted line that moves to a new output exactly one edge after the rewrite, byte-lane selective writes with readback, and the swizzle table across all slots and pins.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
  localparam int LINES     = 4;
  localparam int IRQS      = 16;
  localparam int IRQ_W     = $clog2(IRQS);
  localparam int LINE_W    = $clog2(LINES);
  localparam int DW_W      = 6;
  localparam int SLOT_W    = 5;
  localparam logic [DW_W-1:0] ROUTE_DW = 6'h18;
  localparam logic [7:0] ROUTE_RESET = 8'h80;

  typedef logic [LINES-1:0][7:0] routeBytes_t;

  typedef struct packed {
    logic [LINES-1:0] wrLine;
    routeBytes_t      wrByte;
  } routeStrobe_t;
endpackage

// File: rtl/intx_router_ctrl.sv
module intx_router_ctrl
  import intx_router_pkg::*;
(
  input  logic              cfgWrEn,
  input  logic [DW_W-1:0]   cfgDwAddr,
  input  logic [LINES-1:0]  cfgByteEn,
  input  logic [31:0]       cfgWrData,
  input  routeBytes_t       routeBytes,
  output logic [31:0]       cfgRdData,
  input  logic [SLOT_W-1:0] devSlot,
  input  logic [1:0]        devPin,
  output logic [LINE_W-1:0] swizPirq,
  output routeStrobe_t      strobe
);
  logic hitRoute;
  assign hitRoute = (cfgDwAddr == ROUTE_DW);

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    assign strobe.wrLine[i] = cfgWrEn && hitRoute && cfgByteEn[i];
    assign strobe.wrByte[i] = cfgWrData[8*i +: 8];
  end

  assign cfgRdData = hitRoute ? 32'(routeBytes) : 32'd0;

  assign swizPirq = LINE_W'(SLOT_W'(devPin) + devSlot - SLOT_W'(1));
endmodule

// File: rtl/intx_router_dp.sv
module intx_router_dp
  import intx_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  routeStrobe_t      strobe,
  input  logic [LINES-1:0]  lineLevel,
  input  logic [LINE_W-1:0] qryLine,
  output routeBytes_t       routeBytes,
  output logic              qryEnable,
  output logic [IRQ_W:0]    qryTarget,
  output logic [IRQS-1:0]   irqOut
);
  logic [IRQS-1:0] nextOut;

  for (genvar l = 0; l < LINES; l++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rstN)                 routeBytes[l] <= ROUTE_RESET;
      else if (strobe.wrLine[l]) routeBytes[l] <= strobe.wrByte[l];
    end
  end

  always_comb begin
    nextOut = '0;
    for (int l = 0; l < LINES; l++) begin
      if (routeBytes[l] < 8'(IRQS) && lineLevel[l])
        nextOut[routeBytes[l][IRQ_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= nextOut;
  end

  always_comb begin
    qryEnable = routeBytes[qryLine] < 8'(IRQS);
    qryTarget = qryEnable ? (IRQ_W+1)'(routeBytes[qryLine][IRQ_W-1:0]) : '1;
  end
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_router_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lineLevel,
  input  logic              cfgWrEn,
  input  logic [DW_W-1:0]   cfgDwAddr,
  input  logic [LINES-1:0]  cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic [SLOT_W-1:0] devSlot,
  input  logic [1:0]        devPin,
  output logic [LINE_W-1:0] swizPirq,
  input  logic [LINE_W-1:0] qryLine,
  output logic              qryEnable,
  output logic [IRQ_W:0]    qryTarget,
  output logic [IRQS-1:0]   irqOut
);
  routeStrobe_t strobe;
  routeBytes_t  routeBytes;

  intx_router_ctrl u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgDwAddr(cfgDwAddr), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .routeBytes(routeBytes), .cfgRdData(cfgRdData),
    .devSlot(devSlot), .devPin(devPin), .swizPirq(swizPirq), .strobe(strobe)
  );

  intx_router_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineLevel(lineLevel),
    .qryLine(qryLine), .routeBytes(routeBytes), .qryEnable(qryEnable),
    .qryTarget(qryTarget), .irqOut(irqOut)
  );
endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk
  import intx_router_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [LINES-1:0] lineLevel,
  input logic             cfgWrEn,
  input routeBytes_t      routeBytes,
  input logic             qryEnable,
  input logic [IRQ_W:0]   qryTarget,
  input logic [IRQS-1:0]  irqOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (irqOut == '0) && (routeBytes == {LINES{ROUTE_RESET}}));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lineLevel) == '0) |-> (irqOut == '0));

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqOut) <= $countones($past(lineLevel)));

  // R6
  route_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(routeBytes));

  // R9
  qry_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    qryEnable |-> (qryTarget < (IRQ_W+1)'(IRQS)));

  // R9
  qry_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !qryEnable |-> (qryTarget == '1));
endmodule

bind intx_router intx_router_chk u_chk (
  .clk(clk), .rstN(rstN), .lineLevel(lineLevel), .cfgWrEn(cfgWrEn),
  .routeBytes(routeBytes), .qryEnable(qryEnable), .qryTarget(qryTarget),
  .irqOut(irqOut)
);

// File: tb/intx_router_tb.sv
`timescale 1ns/1ps
module intx_router_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  lineLevel = 0;
  logic        cfgWrEn = 0;
  logic [5:0]  cfgDwAddr = 0;
  logic [3:0]  cfgByteEn = 0;
  logic [31:0] cfgWrData = 0;
  logic [31:0] cfgRdData;
  logic [4:0]  devSlot = 0;
  logic [1:0]  devPin = 0;
  logic [1:0]  swizPirq;
  logic [1:0]  qryLine = 0;
  logic        qryEnable;
  logic [4:0]  qryTarget;
  logic [15:0] irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] routeM [4];

  always #2 clk = ~clk;

  intx_router u_dut (
    .clk(clk), .rstN(rstN), .lineLevel(lineLevel), .cfgWrEn(cfgWrEn),
    .cfgDwAddr(cfgDwAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .devSlot(devSlot), .devPin(devPin),
    .swizPirq(swizPirq), .qryLine(qryLine), .qryEnable(qryEnable),
    .qryTarget(qryTarget), .irqOut(irqOut)
  );

  function automatic logic [15:0] expOut(logic [3:0] lv);
    logic [15:0] o = '0;
    for (int l = 0; l < 4; l++)
      if (routeM[l] < 16 && lv[l]) o[routeM[l][3:0]] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] expRead(logic [5:0] dw);
    return (dw == 6'h18) ? {routeM[3], routeM[2], routeM[1], routeM[0]} : 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgDwAddr = dw; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    if (dw == 6'h18)
      for (int i = 0; i < 4; i++) if (be[i]) routeM[i] = d[8*i +: 8];
  endtask

  task automatic setLevels(logic [3:0] v);
    @(negedge clk);
    lineLevel = v;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) routeM[i] = 8'h80;
    lineLevel = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out", 32'(irqOut), 0);
    cfgDwAddr = 6'h18;
    #0.1;
    chk("R1 bytes", cfgRdData, 32'h80808080);
    for (int q = 0; q < 4; q++) begin
      qryLine = 2'(q); #0.1;
      chk("R1 qry", {qryEnable, qryTarget}, {1'b0, 5'h1F});
    end
    rstN = 1;
    lineLevel = 0;
    @(negedge clk);
    // R3 disconnected lines toggle without effect
    setLevels(4'hF);
    chk("R3 disabled toggle", 32'(irqOut), 0);
    // R2 basic route A->5
    cfgWrite(6'h18, 4'b0001, 32'h00000005);
    @(negedge clk);
    chk("R2 route A", 32'(irqOut), 32'h20);
    // R4 A and B both to 5
    cfgWrite(6'h18, 4'b0010, 32'h00000500);
    setLevels(4'b0011);
    chk("R4 both", 32'(irqOut), 32'h20);
    setLevels(4'b0010);
    chk("R4 one released", 32'(irqOut), 32'h20);
    setLevels(4'b0000);
    chk("R4 both released", 32'(irqOut), 0);
    // R5 reroute an asserted line A: 5 -> 12
    setLevels(4'b0001);
    chk("R5 before", 32'(irqOut), 32'h20);
    cfgWrite(6'h18, 4'b0001, 32'h0000000C);
    chk("R5 still old at write edge", 32'(irqOut), 32'h20);
    @(negedge clk);
    chk("R5 moved", 32'(irqOut), 32'h1000);
    // R3 disable asserted line
    cfgWrite(6'h18, 4'b0001, 32'h00000010);
    @(negedge clk);
    chk("R3 value 16 disables", 32'(irqOut), 0);
    // R6 other dword ignored
    cfgWrite(6'h19, 4'hF, 32'h01020304);
    cfgDwAddr = 6'h18; #0.1;
    chk("R6 other dword", cfgRdData, expRead(6'h18));
    // R7 read elsewhere
    cfgDwAddr = 6'h00; #0.1;
    chk("R7 other read", cfgRdData, 0);
    // R8 swizzle table
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        devSlot = 5'(s); devPin = 2'(p); #0.1;
        chk("R8 swizzle", 32'(swizPirq), 32'((p + s + 3) % 4));
      end
    // random mix: R2 R3 R4 R6 R7 R9 R10
    for (int it = 0; it < 200; it++) begin
      logic [31:0] d;
      logic [5:0]  dw;
      for (int b = 0; b < 4; b++) begin
        int k = $urandom % 3;
        d[8*b +: 8] = (k == 0) ? 8'($urandom % 16) :
                      (k == 1) ? 8'($urandom) : 8'h80;
      end
      dw = ($urandom % 4 == 0) ? 6'($urandom) : 6'h18;
      cfgWrite(dw, 4'($urandom), d);
      @(negedge clk);
      lineLevel = 4'($urandom);
      @(negedge clk);
      chk("R4 random out", 32'(irqOut), 32'(expOut(lineLevel)));
      cfgDwAddr = 6'($urandom); #0.1;
      chk("R7 random read", cfgRdData, expRead(cfgDwAddr));
      qryLine = 2'($urandom); #0.1;
      if (routeM[qryLine] < 16)
        chk("R9 query", {qryEnable, qryTarget}, {1'b1, routeM[qryLine][4:0]});
      else
        chk("R9 query", {qryEnable, qryTarget}, {1'b0, 5'h1F});
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule